// File: doc/BRIEF.md
# SCSI Controller Command Decoder

This block sits behind the command register of a SCSI host controller. Each time the host strobes a command byte into it, the block splits the byte into a seven-bit opcode and a DMA flag. For the simple commands it works out the new contents of the interrupt-cause, status, sequence-step and FIFO-flag registers. It hands each new value to the surrounding register file together with a write enable, and it asks for an interrupt where the command calls for one. For the selection commands and the transfer command it emits a one-cycle start pulse toward the sequencer that carries the command out.

When a DMA flavour of a start command arrives while the DMA engine's enable input is low, the start is parked and released once the enable is seen high. Any DMA-flagged command also requests a reload of the transfer counter. Opcodes outside the supported set change nothing and produce an illegal-command pulse.

The register file, the interrupt line itself and the sequencers are outside this block. The current status value comes in as an input so that commands which merge bits into status can do so.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after release, every write enable, the interrupt request, the illegal-command flag, the counter-load request and all four start outputs are 0. All register value outputs are zero.
- R2: A command is decoded only in a cycle where `host_wr` is high, and its effects appear on the outputs in the next cycle for one cycle. A cycle without a write produces no write enable, interrupt, illegal flag or counter load.
- R3: Bit 7 of `host_cmd` is the DMA flag and bits 6:0 are the opcode. Any write with the DMA flag set raises `cnt_load` in the next cycle, whatever the opcode.
- R4: Flush (opcode 0x01) writes cause 0x08, sequence step 0 and FIFO flags 0, leaves status alone, and requests an interrupt.
- R5: Bus reset (opcode 0x03) writes cause 0x80 and leaves status, step and flags alone. It requests an interrupt only if `cfg_rpt_dis` is low in the write cycle.
- R6: Initiator completion (opcode 0x11) writes cause 0x08, writes status as `stat_i` with bits 2:0 set (the message-in phase), and requests an interrupt.
- R7: Message accepted (opcode 0x12) writes cause 0x20, step 0 and flags 0, and requests an interrupt.
- R8: Pad transfer (opcode 0x18) writes status 0x10, cause 0x08 and step 0. It leaves flags alone and requests no interrupt.
- R9: Enable selection (0x44) and disable selection (0x45) write cause 0 only, with no interrupt.
- R10: Select (0x41), select with attention (0x42), select with attention and stop (0x43) and transfer (0x10) pulse `start_sel`, `start_atn`, `start_stop` and `start_xfer` respectively in the next cycle. This happens when the DMA flag is clear or `dma_en` is high at the write.
- R11: A start command with the DMA flag set while `dma_en` is low pulses nothing at first. Its start pulse comes in the cycle after the first later cycle in which `dma_en` is high. Any new write before that discards the parked start.
- R12: No-op (0x00) has no effect. Any other unlisted opcode pulses `illegal_cmd` and produces no write enable, interrupt or start.
- R13: At most one start output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Command write strobe |
| host_cmd | input | 8 | Command byte: DMA flag in bit 7, opcode below |
| cfg_rpt_dis | input | 1 | Suppresses the interrupt for bus reset |
| dma_en | input | 1 | DMA engine enable |
| stat_i | input | 8 | Current status register contents |
| cause_o | output | 8 | New interrupt-cause value |
| cause_we | output | 1 | Write enable for cause |
| stat_o | output | 8 | New status value |
| stat_we | output | 1 | Write enable for status |
| seq_o | output | 3 | New sequence-step value |
| seq_we | output | 1 | Write enable for sequence step |
| flags_o | output | 5 | New FIFO-flag value |
| flags_we | output | 1 | Write enable for FIFO flags |
| irq_req | output | 1 | Interrupt request pulse |
| illegal_cmd | output | 1 | Unknown opcode pulse |
| cnt_load | output | 1 | Transfer counter reload pulse |
| start_sel | output | 1 | Start select without attention |
| start_atn | output | 1 | Start select with attention |
| start_stop | output | 1 | Start select with attention and stop |
| start_xfer | output | 1 | Start information transfer |

## Verification
The hardest state to reach is a parked DMA start. It must see `dma_en` stay low for several cycles, and then either be released by a rising enable or be overwritten by a later command of a different kind. Random cycles alternate write and idle slots with `dma_en` drawn independently, so parked starts arise, sometimes survive idle cycles and sometimes meet a new write. Directed sequences hold the enable low for a fixed stretch before raising it and cancel a parked start with a no-op and with another select. A bench model tracks the parked kind to predict each pulse.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

  localparam int OPC_W = 7;

  localparam logic [OPC_W-1:0] OP_NOP     = 7'h00;
  localparam logic [OPC_W-1:0] OP_FLUSH   = 7'h01;
  localparam logic [OPC_W-1:0] OP_BUSRST  = 7'h03;
  localparam logic [OPC_W-1:0] OP_XFER    = 7'h10;
  localparam logic [OPC_W-1:0] OP_ICCS    = 7'h11;
  localparam logic [OPC_W-1:0] OP_MSGOK   = 7'h12;
  localparam logic [OPC_W-1:0] OP_PAD     = 7'h18;
  localparam logic [OPC_W-1:0] OP_SEL     = 7'h41;
  localparam logic [OPC_W-1:0] OP_SELATN  = 7'h42;
  localparam logic [OPC_W-1:0] OP_SELSTOP = 7'h43;
  localparam logic [OPC_W-1:0] OP_ENSEL   = 7'h44;
  localparam logic [OPC_W-1:0] OP_DISSEL  = 7'h45;

  localparam int N_START = 4;

  typedef enum logic [2:0] {
    GO_NONE    = 3'd0,
    GO_SEL     = 3'd1,
    GO_SELATN  = 3'd2,
    GO_SELSTOP = 3'd3,
    GO_XFER    = 3'd4
  } go_e;

  typedef enum logic [1:0] {
    ST_KEEP,
    ST_LOAD,
    ST_MERGE
  } stat_mode_e;

  typedef enum logic [1:0] {
    CS_DONE,
    CS_DISC,
    CS_BUSRST,
    CS_ZERO
  } cause_sel_e;

  typedef enum logic [1:0] {
    IRQ_NO,
    IRQ_YES,
    IRQ_CFG
  } irq_mode_e;

  typedef struct packed {
    logic       cause_we;
    cause_sel_e cause_sel;
    stat_mode_e stat_mode;
    logic       seq_zero;
    logic       flag_zero;
    irq_mode_e  irq_mode;
    go_e        go;
    logic       illegal;
  } effect_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_cmd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output effect_t          eff
);

  always_comb begin
    eff           = '0;
    eff.cause_sel = CS_ZERO;
    eff.stat_mode = ST_KEEP;
    eff.irq_mode  = IRQ_NO;
    eff.go        = GO_NONE;
    case (opcode)
      OP_NOP: ;
      OP_FLUSH: begin
        eff.cause_we  = 1'b1;
        eff.cause_sel = CS_DONE;
        eff.seq_zero  = 1'b1;
        eff.flag_zero = 1'b1;
        eff.irq_mode  = IRQ_YES;
      end
      OP_BUSRST: begin
        eff.cause_we  = 1'b1;
        eff.cause_sel = CS_BUSRST;
        eff.irq_mode  = IRQ_CFG;
      end
      OP_ICCS: begin
        eff.cause_we  = 1'b1;
        eff.cause_sel = CS_DONE;
        eff.stat_mode = ST_MERGE;
        eff.irq_mode  = IRQ_YES;
      end
      OP_MSGOK: begin
        eff.cause_we  = 1'b1;
        eff.cause_sel = CS_DISC;
        eff.seq_zero  = 1'b1;
        eff.flag_zero = 1'b1;
        eff.irq_mode  = IRQ_YES;
      end
      OP_PAD: begin
        eff.cause_we  = 1'b1;
        eff.cause_sel = CS_DONE;
        eff.stat_mode = ST_LOAD;
        eff.seq_zero  = 1'b1;
      end
      OP_ENSEL, OP_DISSEL: begin
        eff.cause_we  = 1'b1;
        eff.cause_sel = CS_ZERO;
      end
      OP_SEL:     eff.go = GO_SEL;
      OP_SELATN:  eff.go = GO_SELATN;
      OP_SELSTOP: eff.go = GO_SELSTOP;
      OP_XFER:    eff.go = GO_XFER;
      default:    eff.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/scsi_start_dispatch.sv
module scsi_start_dispatch
  import scsi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  go_e                go,
  input  logic               dma_req,
  input  logic               dma_en,
  output logic [N_START-1:0] start_q
);

  go_e                pend_q, pend_n;
  go_e                fire_kind;
  logic [N_START-1:0] fire_n;

  always_comb begin
    pend_n    = pend_q;
    fire_kind = GO_NONE;
    if (wr) begin
      pend_n = GO_NONE;
      if (go != GO_NONE) begin
        if (dma_req && !dma_en) pend_n    = go;
        else                    fire_kind = go;
      end
    end else if ((pend_q != GO_NONE) && dma_en) begin
      fire_kind = pend_q;
      pend_n    = GO_NONE;
    end
  end

  for (genvar k = 0; k < N_START; k++) begin : g_fire
    assign fire_n[k] = (fire_kind == go_e'(k + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= GO_NONE;
      start_q <= '0;
    end else begin
      pend_q  <= pend_n;
      start_q <= fire_n;
    end
  end

endmodule

// File: rtl/scsi_reg_update.sv
module scsi_reg_update
  import scsi_cmd_pkg::*;
#(
  parameter int              STAT_W       = 8,
  parameter int              CAUSE_W      = 8,
  parameter int              SEQ_W        = 3,
  parameter int              FLAG_W       = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_DONE   = 8'h08,
  parameter logic [CAUSE_W-1:0] CAUSE_DISC   = 8'h20,
  parameter logic [CAUSE_W-1:0] CAUSE_BUSRST = 8'h80,
  parameter logic [STAT_W-1:0]  STAT_CNT0    = 8'h10,
  parameter logic [STAT_W-1:0]  STAT_MSGIN   = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  effect_t            eff,
  input  logic               dma_req,
  input  logic               cfg_rpt_dis,
  input  logic [STAT_W-1:0]  stat_i,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               cause_we_q,
  output logic [STAT_W-1:0]  stat_q,
  output logic               stat_we_q,
  output logic [SEQ_W-1:0]   seq_q,
  output logic               seq_we_q,
  output logic [FLAG_W-1:0]  flags_q,
  output logic               flags_we_q,
  output logic               irq_q,
  output logic               illegal_q,
  output logic               load_q
);

  logic [CAUSE_W-1:0] cause_n;
  logic [STAT_W-1:0]  stat_n;
  logic               cause_we_n, stat_we_n, seq_we_n, flags_we_n;
  logic               irq_n, illegal_n, load_n;

  always_comb begin
    cause_we_n = wr && eff.cause_we;
    stat_we_n  = wr && (eff.stat_mode != ST_KEEP);
    seq_we_n   = wr && eff.seq_zero;
    flags_we_n = wr && eff.flag_zero;
    illegal_n  = wr && eff.illegal;
    load_n     = wr && dma_req;
    irq_n      = wr && ((eff.irq_mode == IRQ_YES) ||
                        ((eff.irq_mode == IRQ_CFG) && !cfg_rpt_dis));
    case (eff.cause_sel)
      CS_DONE:   cause_n = CAUSE_DONE;
      CS_DISC:   cause_n = CAUSE_DISC;
      CS_BUSRST: cause_n = CAUSE_BUSRST;
      default:   cause_n = '0;
    endcase
    if (eff.stat_mode == ST_MERGE) stat_n = stat_i | STAT_MSGIN;
    else                           stat_n = STAT_CNT0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_we_q <= 1'b0;
      stat_we_q  <= 1'b0;
      seq_we_q   <= 1'b0;
      flags_we_q <= 1'b0;
      irq_q      <= 1'b0;
      illegal_q  <= 1'b0;
      load_q     <= 1'b0;
    end else begin
      cause_we_q <= cause_we_n;
      stat_we_q  <= stat_we_n;
      seq_we_q   <= seq_we_n;
      flags_we_q <= flags_we_n;
      irq_q      <= irq_n;
      illegal_q  <= illegal_n;
      load_q     <= load_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      stat_q  <= '0;
      seq_q   <= '0;
      flags_q <= '0;
    end else begin
      if (cause_we_n) cause_q <= cause_n;
      if (stat_we_n)  stat_q  <= stat_n;
      if (seq_we_n)   seq_q   <= '0;
      if (flags_we_n) flags_q <= '0;
    end
  end

endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
  import scsi_cmd_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int CAUSE_W = 8,
  parameter int SEQ_W   = 3,
  parameter int FLAG_W  = 5,
  localparam int CMD_W  = OPC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [CMD_W-1:0]   host_cmd,
  input  logic               cfg_rpt_dis,
  input  logic               dma_en,
  input  logic [STAT_W-1:0]  stat_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               cause_we,
  output logic [STAT_W-1:0]  stat_o,
  output logic               stat_we,
  output logic [SEQ_W-1:0]   seq_o,
  output logic               seq_we,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               flags_we,
  output logic               irq_req,
  output logic               illegal_cmd,
  output logic               cnt_load,
  output logic               start_sel,
  output logic               start_atn,
  output logic               start_stop,
  output logic               start_xfer
);

  logic [OPC_W-1:0]   opcode;
  logic               dma_req;
  effect_t            eff;
  logic [N_START-1:0] starts;

  assign opcode  = host_cmd[OPC_W-1:0];
  assign dma_req = host_cmd[CMD_W-1];

  scsi_cmd_decode u_decode (
    .opcode (opcode),
    .eff    (eff)
  );

  scsi_start_dispatch u_dispatch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_wr),
    .go      (eff.go),
    .dma_req (dma_req),
    .dma_en  (dma_en),
    .start_q (starts)
  );

  scsi_reg_update #(
    .STAT_W  (STAT_W),
    .CAUSE_W (CAUSE_W),
    .SEQ_W   (SEQ_W),
    .FLAG_W  (FLAG_W)
  ) u_update (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (host_wr),
    .eff         (eff),
    .dma_req     (dma_req),
    .cfg_rpt_dis (cfg_rpt_dis),
    .stat_i      (stat_i),
    .cause_q     (cause_o),
    .cause_we_q  (cause_we),
    .stat_q      (stat_o),
    .stat_we_q   (stat_we),
    .seq_q       (seq_o),
    .seq_we_q    (seq_we),
    .flags_q     (flags_o),
    .flags_we_q  (flags_we),
    .irq_q       (irq_req),
    .illegal_q   (illegal_cmd),
    .load_q      (cnt_load)
  );

  assign start_sel  = starts[0];
  assign start_atn  = starts[1];
  assign start_stop = starts[2];
  assign start_xfer = starts[3];

endmodule

// File: rtl/scsi_cmd_decoder_chk.sv
module scsi_cmd_decoder_chk
  import scsi_cmd_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int CAUSE_W = 8,
  parameter int SEQ_W   = 3,
  parameter int FLAG_W  = 5,
  localparam int CMD_W  = OPC_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr,
  input logic [CMD_W-1:0]   host_cmd,
  input logic               cfg_rpt_dis,
  input logic               dma_en,
  input logic [STAT_W-1:0]  stat_i,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               cause_we,
  input logic [STAT_W-1:0]  stat_o,
  input logic               stat_we,
  input logic [SEQ_W-1:0]   seq_o,
  input logic               seq_we,
  input logic [FLAG_W-1:0]  flags_o,
  input logic               flags_we,
  input logic               irq_req,
  input logic               illegal_cmd,
  input logic               cnt_load,
  input logic               start_sel,
  input logic               start_atn,
  input logic               start_stop,
  input logic               start_xfer
);

  logic any_we;
  assign any_we = cause_we | stat_we | seq_we | flags_we;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_wr) |-> !(any_we || irq_req || illegal_cmd || cnt_load));

  assert_load_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> $past(host_wr && host_cmd[CMD_W-1]));

  assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_cmd[OPC_W-1:0] == OP_FLUSH) |->
      (cause_we && cause_o == 8'h08 && seq_we && seq_o == '0 &&
       flags_we && flags_o == '0 && irq_req && !stat_we));

  assert_busrst_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_cmd[OPC_W-1:0] == OP_BUSRST && cfg_rpt_dis) |->
      (!irq_req && !stat_we && cause_we && cause_o == 8'h80));

  assert_iccs_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_cmd[OPC_W-1:0] == OP_ICCS) |->
      (stat_we && stat_o == ($past(stat_i) | 8'h07)));

  assert_illegal_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> !(any_we || irq_req ||
                      start_sel || start_atn || start_stop || start_xfer));

  assert_one_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_sel, start_atn, start_stop, start_xfer}));

endmodule

bind scsi_cmd_decoder scsi_cmd_decoder_chk #(
  .STAT_W  (STAT_W),
  .CAUSE_W (CAUSE_W),
  .SEQ_W   (SEQ_W),
  .FLAG_W  (FLAG_W)
) u_chk (.*);

// File: tb/scsi_cmd_decoder_tb.sv
`timescale 1ns/1ps
module scsi_cmd_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr;
  logic [7:0] host_cmd;
  logic       cfg_rpt_dis;
  logic       dma_en;
  logic [7:0] stat_i;
  logic [7:0] cause_o, stat_o;
  logic [2:0] seq_o;
  logic [4:0] flags_o;
  logic cause_we, stat_we, seq_we, flags_we;
  logic irq_req, illegal_cmd, cnt_load;
  logic start_sel, start_atn, start_stop, start_xfer;

  int errors = 0;
  int checks = 0;
  int pend   = 0;   // 0 none, 1 sel, 2 atn, 3 stop, 4 xfer

  always #2.5 clk = ~clk;

  scsi_cmd_decoder dut_i (.*);

  // expected bundle
  logic       e_cwe, e_swe, e_qwe, e_fwe, e_irq, e_ill, e_ld;
  logic [7:0] e_cause, e_stat;
  logic [3:0] e_start;

  function automatic int start_kind(input logic [6:0] op);
    case (op)
      7'h41: return 1;
      7'h42: return 2;
      7'h43: return 3;
      7'h10: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit known(input logic [6:0] op);
    case (op)
      7'h00, 7'h01, 7'h03, 7'h10, 7'h11, 7'h12, 7'h18,
      7'h41, 7'h42, 7'h43, 7'h44, 7'h45: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input bit wr, input logic [7:0] c, input bit den);
    if (!wr) return "R11/R2";
    case (c[6:0])
      7'h00: return "R12";
      7'h01: return "R4";
      7'h03: return "R5";
      7'h11: return "R6";
      7'h12: return "R7";
      7'h18: return "R8";
      7'h44, 7'h45: return "R9";
      7'h41, 7'h42, 7'h43, 7'h10: return (c[7] && !den) ? "R11" : "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic predict(input bit wr, input logic [7:0] c, input bit cfg,
                         input bit den, input logic [7:0] st);
    logic [6:0] op;
    int k;
    op = c[6:0];
    {e_cwe, e_swe, e_qwe, e_fwe, e_irq, e_ill, e_ld} = '0;
    e_cause = '0; e_stat = '0; e_start = '0;
    if (wr) begin
      e_ld = c[7];
      pend = 0;
      case (op)
        7'h01: begin e_cwe = 1; e_cause = 8'h08; e_qwe = 1; e_fwe = 1; e_irq = 1; end
        7'h03: begin e_cwe = 1; e_cause = 8'h80; e_irq = !cfg; end
        7'h11: begin e_cwe = 1; e_cause = 8'h08; e_swe = 1; e_stat = st | 8'h07; e_irq = 1; end
        7'h12: begin e_cwe = 1; e_cause = 8'h20; e_qwe = 1; e_fwe = 1; e_irq = 1; end
        7'h18: begin e_cwe = 1; e_cause = 8'h08; e_swe = 1; e_stat = 8'h10; e_qwe = 1; end
        7'h44, 7'h45: begin e_cwe = 1; e_cause = 8'h00; end
        default: if (!known(op)) e_ill = 1;
      endcase
      k = start_kind(op);
      if (k != 0) begin
        if (c[7] && !den) pend = k;
        else e_start[k-1] = 1'b1;
      end
    end else if (pend != 0 && den) begin
      e_start[pend-1] = 1'b1;
      pend = 0;
    end
  endtask

  task automatic compare(input string tag);
    bit bad;
    bad = (cause_we != e_cwe) || (stat_we != e_swe) || (seq_we != e_qwe) ||
          (flags_we != e_fwe) || (irq_req != e_irq) || (illegal_cmd != e_ill) ||
          (cnt_load != e_ld) ||
          ({start_xfer, start_stop, start_atn, start_sel} != e_start) ||
          (e_cwe && cause_o != e_cause) || (e_swe && stat_o != e_stat) ||
          (e_qwe && seq_o != 3'd0) || (e_fwe && flags_o != 5'd0);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: got we=%b%b%b%b irq=%b ill=%b ld=%b st=%b cause=%h stat=%h exp we=%b%b%b%b irq=%b ill=%b ld=%b st=%b cause=%h stat=%h",
        tag, cause_we, stat_we, seq_we, flags_we, irq_req, illegal_cmd, cnt_load,
        {start_xfer, start_stop, start_atn, start_sel}, cause_o, stat_o,
        e_cwe, e_swe, e_qwe, e_fwe, e_irq, e_ill, e_ld, e_start, e_cause, e_stat);
    end
  endtask

  // drive one cycle (called just after a negedge), check after the next posedge
  task automatic cyc(input bit wr, input logic [7:0] c, input bit cfg,
                     input bit den, input logic [7:0] st, input string tag);
    host_wr = wr; host_cmd = c; cfg_rpt_dis = cfg; dma_en = den; stat_i = st;
    predict(wr, c, cfg, den, st);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic check_reset();
    checks++;
    if ({cause_we, stat_we, seq_we, flags_we, irq_req, illegal_cmd, cnt_load,
         start_sel, start_atn, start_stop, start_xfer} != '0 ||
        cause_o != 0 || stat_o != 0 || seq_o != 0 || flags_o != 0) begin
      errors++;
      $display("FAIL R1: outputs not cleared, cause=%h stat=%h seq=%h flags=%h exp all 0",
               cause_o, stat_o, seq_o, flags_o);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] codes [12];
    codes = '{8'h00, 8'h01, 8'h03, 8'h10, 8'h11, 8'h12, 8'h18,
              8'h41, 8'h42, 8'h43, 8'h44, 8'h45};
    void'($urandom(32'd1357));
    rst_n = 1'b0; host_wr = 0; host_cmd = 0; cfg_rpt_dis = 0; dma_en = 0; stat_i = 0;
    repeat (3) @(negedge clk);
    check_reset();                       // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();                       // R1 after release

    // directed
    cyc(1, 8'h01, 0, 0, 8'h5A, "R4");
    cyc(0, 8'h00, 0, 0, 8'h00, "R2");
    cyc(1, 8'h03, 0, 0, 8'h00, "R5");
    cyc(1, 8'h03, 1, 0, 8'h00, "R5");
    cyc(1, 8'h11, 0, 0, 8'hA0, "R6");
    cyc(1, 8'h12, 0, 0, 8'h00, "R7");
    cyc(1, 8'h98, 0, 0, 8'h00, "R8/R3");
    cyc(1, 8'h44, 0, 0, 8'h00, "R9");
    cyc(1, 8'h45, 0, 0, 8'h00, "R9");
    cyc(1, 8'h80, 0, 0, 8'h00, "R3/R12");
    cyc(1, 8'h7F, 0, 0, 8'h00, "R12");
    cyc(1, 8'h41, 0, 0, 8'h00, "R10");
    cyc(1, 8'hC2, 0, 1, 8'h00, "R10");
    // parked start released after a long low enable
    cyc(1, 8'hC3, 0, 0, 8'h00, "R11");
    for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 0, 8'h00, "R11");
    cyc(0, 8'h00, 0, 1, 8'h00, "R11");
    cyc(0, 8'h00, 0, 1, 8'h00, "R11");
    // parked start cancelled by no-op, then by another select
    cyc(1, 8'h90, 0, 0, 8'h00, "R11");
    cyc(1, 8'h00, 0, 0, 8'h00, "R11");
    cyc(0, 8'h00, 0, 1, 8'h00, "R11");
    cyc(1, 8'hC1, 0, 0, 8'h00, "R11");
    cyc(1, 8'hC2, 0, 0, 8'h00, "R11");
    cyc(0, 8'h00, 0, 1, 8'h00, "R11/R13");

    // random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      bit den, cfg;
      if ($urandom_range(0, 9) < 3) c = 8'($urandom);
      else c = {1'($urandom), codes[$urandom_range(0, 11)][6:0]};
      den = 1'($urandom);
      cfg = 1'($urandom);
      cyc(1, c, cfg, den, 8'($urandom), tag_of(1, c, den));
      repeat ($urandom_range(0, 2)) begin
        den = ($urandom_range(0, 3) == 0);
        cyc(0, 8'($urandom), cfg, den, 8'($urandom), tag_of(0, 8'h00, den));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule